// File: doc/BRIEF.md
# Gated Row SAD Array

This block is the arithmetic core of a full-search motion estimator that covers one horizontal row of search offsets at a time. It holds one processing element (PE) per horizontal offset, 32 by default for offsets −16 to +15. A reference (candidate) pixel is broadcast to every PE in the same cycle. The current-block pixel stream instead walks down a register line, so PE k works on the current pixel that entered k cycles earlier. Each PE sums absolute differences over a 16×16 block, which is 256 pixels. The fetch logic outside orders the reference stream so that this skew lines up each PE with its own offset.

Every PE has an enable for power saving. While the enable is low, the PE's pixel operands are forced to zero so its subtractor stops toggling, and its accumulator is held. A pruning controller upstream uses this to switch off offsets that look poor.

So that such a controller can decide, each PE reports its running sum after every 64 accumulated pixels: after block rows 4, 8, 12 and the final 16. The report carries a strobe, the PE index and a flag marking the complete sum. Because the PEs are skewed by one cycle each, the reports of different PEs never coincide, and a single shared report port carries them all. Passes may follow each other with no gap, so a 32-row search takes 32 × 256 = 8192 cycles of input.

Top module: `sad_row_array`

## Requirements
- R1: While reset is held, and in every cycle after reset until the first report point is reached, `rep_vld` is 0.
- R2: PE k adds |C − R| each cycle it receives a valid pixel. C is the current pixel presented at the input k cycles earlier, and R is the reference pixel presented in the same cycle.
- R3: A PE reports when the pixel at block index i reaches it with i mod 64 = 63, in that same cycle. The reported sum includes that pixel. PE0 therefore reports 63, 127, 191 and 255 cycles after the first pixel of an unstalled pass, and PE k reports k cycles after PE0.
- R4: `rep_tag` is the index of the reporting PE. `rep_last` is 1 only with a report at block index 255, the complete SAD.
- R5: The input marked by `cur_first` has block index 0. The sum at each PE restarts from that pixel's difference and drops anything before it, including a pass cut short.
- R6: While `pe_en[k]` is 0, PE k adds nothing and its sum is held, except that a block-index-0 pixel sets the sum to 0. PE k makes no report in such a cycle. Once re-enabled, it continues from the held sum.
- R7: The 16-bit sum holds the largest possible total, 256 × 255 = 65280, without wrapping.
- R8: At most one PE reports in any cycle.
- R9: A new pass may start in the cycle after the index-255 pixel of the previous pass. Both passes are then reported correctly while their pixels overlap along the line.
- R10: A cycle with `cur_vld` at 0 is a bubble that travels down the line. No PE accumulates or advances its block index on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cur_vld | input | 1 | Current-block pixel valid |
| cur_first | input | 1 | Marks block index 0 of a pass |
| cur_pix | input | 8 | Current-block pixel entering the line |
| ref_pix | input | 8 | Reference pixel broadcast to all PEs |
| pe_en | input | 32 | Per-PE enable, bit k for PE k |
| rep_vld | output | 1 | A PE reports this cycle |
| rep_last | output | 1 | The report is the complete SAD |
| rep_tag | output | 5 | Index of the reporting PE |
| rep_sad | output | 16 | Reported sum |

## Verification
Random current and reference pixels with every PE enabled check the per-PE delay of the current stream against the shared reference. A pixel paired with the wrong delay changes the sums in a way that random data exposes. A saturating pass, with current pixels at 255 and references at 0, separates a correct 16-bit total from a wrapped one. Masks that switch PEs off for a whole pass or toggle them mid-block separate holding the sum from clearing it, and show whether report strobes are suppressed. Passes with bubbles, passes that follow each other with no gap, and a pass cut short by a new first pixel separate correct index tracking along the line from tracking based on cycle counts.

// File: rtl/sad_pkg.sv
`timescale 1ns/1ps
// Package: default sizes shared by the row SAD array and its bench.
// Assumes: block of 16x16 pixels, report interval of four block rows.
package sad_pkg;
    localparam int unsigned DEF_NUM_PE  = 32;
    localparam int unsigned DEF_PIX_W   = 8;
    localparam int unsigned DEF_SAD_W   = 16;
    localparam int unsigned DEF_BLK_PIX = 256;
    localparam int unsigned DEF_CHK_PIX = 64;
endpackage

// File: rtl/sad_cur_line.sv
`timescale 1ns/1ps
// Module: current-pixel line. Numbers incoming valid pixels with a block
// index and delays {valid, index, pixel} by one register per PE.
// Tap 0 is the live input; tap k is the input of k cycles ago.
// Assumes: BLK_PIX is a power of two, so the index fills IDX_W bits exactly.
module sad_cur_line #(
    parameter int unsigned NUM_PE  = 32,
    parameter int unsigned PIX_W   = 8,
    parameter int unsigned BLK_PIX = 256,
    localparam int unsigned IDX_W  = $clog2(BLK_PIX)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_vld,
    input  logic                              in_first,
    input  logic [PIX_W-1:0]                  in_pix,
    output logic [NUM_PE-1:0]                 tap_vld,
    output logic [NUM_PE-1:0][IDX_W-1:0]      tap_idx,
    output logic [NUM_PE-1:0][PIX_W-1:0]      tap_pix
);
    logic [IDX_W-1:0] next_idx;
    logic [IDX_W-1:0] head_idx;

    // Index of the pixel at the head: 0 on a first marker, else the count.
    assign head_idx = in_first ? '0 : next_idx;

    // Counts valid pixels entering the line, wrapping after the last index.
    always_ff @(posedge clk) begin
        if (!rst_n)
            next_idx <= '0;
        else if (in_vld)
            next_idx <= (head_idx == IDX_W'(BLK_PIX - 1)) ? '0 : head_idx + 1'b1;
    end

    assign tap_vld[0] = in_vld;
    assign tap_idx[0] = head_idx;
    assign tap_pix[0] = in_pix;

    genvar k;
    generate
        for (k = 1; k < NUM_PE; k++) begin : g_stage
            // One line register: moves the previous tap on by one cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tap_vld[k] <= 1'b0;
                    tap_idx[k] <= '0;
                    tap_pix[k] <= '0;
                end else begin
                    tap_vld[k] <= tap_vld[k-1];
                    tap_idx[k] <= tap_idx[k-1];
                    tap_pix[k] <= tap_pix[k-1];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sad_pe.sv
`timescale 1ns/1ps
// Module: one SAD processing element. Adds |cur - ref| for each valid
// pixel, restarting at block index 0, and reports the running sum at
// every CHK_PIX-th pixel within that same cycle.
// Assumes: CHK_PIX is a power of two dividing BLK_PIX; SAD_W holds
// BLK_PIX * (2**PIX_W - 1).
module sad_pe #(
    parameter int unsigned PIX_W   = 8,
    parameter int unsigned SAD_W   = 16,
    parameter int unsigned BLK_PIX = 256,
    parameter int unsigned CHK_PIX = 64,
    localparam int unsigned IDX_W  = $clog2(BLK_PIX),
    localparam int unsigned CHK_W  = $clog2(CHK_PIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             vld,
    input  logic [IDX_W-1:0] idx,
    input  logic [PIX_W-1:0] cur,
    input  logic [PIX_W-1:0] refp,
    output logic             rep_vld,
    output logic             rep_last,
    output logic [SAD_W-1:0] rep_sad
);
    logic [PIX_W-1:0] cur_m, ref_m, diff;
    logic [SAD_W-1:0] acc, base, sum;
    logic [SAD_W:0]   sum_wide;
    logic             first;

    // Operand masking: a disabled PE sees constant zeros.
    assign cur_m = en ? cur  : '0;
    assign ref_m = en ? refp : '0;

    // Absolute difference of the masked operands.
    assign diff  = (cur_m > ref_m) ? cur_m - ref_m : ref_m - cur_m;
    assign first = (idx == '0);
    assign base  = first ? '0 : acc;
    assign sum_wide = {1'b0, base} + (SAD_W+1)'(diff);
    assign sum   = sum_wide[SAD_W-1:0];

    // Accumulator: written only when enabled or on a block start (clear).
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (vld && (en || first))
            acc <= sum;
    end

    assign rep_vld  = vld && en && (idx[CHK_W-1:0] == {CHK_W{1'b1}});
    assign rep_last = rep_vld && (idx == IDX_W'(BLK_PIX - 1));
    assign rep_sad  = sum;

    // R7: the running sum never carries out of SAD_W bits.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && en) |-> (sum_wide[SAD_W] == 1'b0));

    // R6: a disabled PE holds its sum unless a block start clears it.
    a_r6_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !(vld && first)) |=> $stable(acc));

    // R5: a block start on a disabled PE leaves a zero sum.
    a_r5_clear_on_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && vld && first) |=> (acc == '0));
endmodule

// File: rtl/sad_report_sel.sv
`timescale 1ns/1ps
// Module: report selector. Merges per-PE report strobes onto one port and
// encodes the index of the reporting PE.
// Assumes: at most one PE strobes per cycle (guaranteed by the PE skew).
module sad_report_sel #(
    parameter int unsigned NUM_PE = 32,
    parameter int unsigned SAD_W  = 16,
    localparam int unsigned TAG_W = $clog2(NUM_PE)
) (
    input  logic [NUM_PE-1:0]             pe_vld,
    input  logic [NUM_PE-1:0]             pe_last,
    input  logic [NUM_PE-1:0][SAD_W-1:0]  pe_sad,
    output logic                          rep_vld,
    output logic                          rep_last,
    output logic [TAG_W-1:0]              rep_tag,
    output logic [SAD_W-1:0]              rep_sad
);
    // AND-OR merge of the strobing PE's fields.
    always_comb begin
        rep_vld  = |pe_vld;
        rep_last = 1'b0;
        rep_tag  = '0;
        rep_sad  = '0;
        for (int k = 0; k < NUM_PE; k++) begin
            if (pe_vld[k]) begin
                rep_last = rep_last | pe_last[k];
                rep_tag  = rep_tag  | TAG_W'(k);
                rep_sad  = rep_sad  | pe_sad[k];
            end
        end
    end
endmodule

// File: rtl/sad_row_array.sv
`timescale 1ns/1ps
// Module: top of the gated row SAD array. One PE per horizontal search
// offset; reference pixels broadcast, current pixels skewed by a line.
// Assumes: NUM_PE <= CHK_PIX so skewed reports never coincide.
module sad_row_array #(
    parameter int unsigned NUM_PE  = sad_pkg::DEF_NUM_PE,
    parameter int unsigned PIX_W   = sad_pkg::DEF_PIX_W,
    parameter int unsigned SAD_W   = sad_pkg::DEF_SAD_W,
    parameter int unsigned BLK_PIX = sad_pkg::DEF_BLK_PIX,
    parameter int unsigned CHK_PIX = sad_pkg::DEF_CHK_PIX,
    localparam int unsigned IDX_W  = $clog2(BLK_PIX),
    localparam int unsigned TAG_W  = $clog2(NUM_PE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cur_vld,
    input  logic              cur_first,
    input  logic [PIX_W-1:0]  cur_pix,
    input  logic [PIX_W-1:0]  ref_pix,
    input  logic [NUM_PE-1:0] pe_en,
    output logic              rep_vld,
    output logic              rep_last,
    output logic [TAG_W-1:0]  rep_tag,
    output logic [SAD_W-1:0]  rep_sad
);
    logic [NUM_PE-1:0]            tap_vld;
    logic [NUM_PE-1:0][IDX_W-1:0] tap_idx;
    logic [NUM_PE-1:0][PIX_W-1:0] tap_pix;
    logic [NUM_PE-1:0]            pe_vld, pe_last;
    logic [NUM_PE-1:0][SAD_W-1:0] pe_sad;

    sad_cur_line #(.NUM_PE(NUM_PE), .PIX_W(PIX_W), .BLK_PIX(BLK_PIX)) i_line (
        .clk(clk), .rst_n(rst_n),
        .in_vld(cur_vld), .in_first(cur_first), .in_pix(cur_pix),
        .tap_vld(tap_vld), .tap_idx(tap_idx), .tap_pix(tap_pix)
    );

    genvar k;
    generate
        for (k = 0; k < NUM_PE; k++) begin : g_pe
            sad_pe #(.PIX_W(PIX_W), .SAD_W(SAD_W), .BLK_PIX(BLK_PIX),
                     .CHK_PIX(CHK_PIX)) i_pe (
                .clk(clk), .rst_n(rst_n), .en(pe_en[k]),
                .vld(tap_vld[k]), .idx(tap_idx[k]),
                .cur(tap_pix[k]), .refp(ref_pix),
                .rep_vld(pe_vld[k]), .rep_last(pe_last[k]), .rep_sad(pe_sad[k])
            );
        end
    endgenerate

    sad_report_sel #(.NUM_PE(NUM_PE), .SAD_W(SAD_W)) i_sel (
        .pe_vld(pe_vld), .pe_last(pe_last), .pe_sad(pe_sad),
        .rep_vld(rep_vld), .rep_last(rep_last), .rep_tag(rep_tag), .rep_sad(rep_sad)
    );

    // R8: the skew keeps per-PE report strobes mutually exclusive.
    a_r8_single_report: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pe_vld));
endmodule

// File: tb/test_sad_row_array.sv
`timescale 1ns/1ps
// Bench: behavioural reference (pixel history arrays, integer sums),
// compared with the shared report port in every cycle.
module test_sad_row_array;
    localparam int CLK_P = 10;
    localparam int NPE   = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cur_vld = 1'b0, cur_first = 1'b0;
    logic [7:0]  cur_pix = '0, ref_pix = '0;
    logic [31:0] pe_en = '1;
    logic        rep_vld, rep_last;
    logic [4:0]  rep_tag;
    logic [15:0] rep_sad;

    int total = 0, bad = 0;
    bit finished = 0;
    int hv[NPE], hi[NPE], hp[NPE], macc[NPE];
    int mcnt = 0;

    always #(CLK_P/2) clk = ~clk;

    sad_row_array i_sad_row_array (
        .clk(clk), .rst_n(rst_n), .cur_vld(cur_vld), .cur_first(cur_first),
        .cur_pix(cur_pix), .ref_pix(ref_pix), .pe_en(pe_en),
        .rep_vld(rep_vld), .rep_last(rep_last), .rep_tag(rep_tag), .rep_sad(rep_sad)
    );

    function automatic int absd(int a, int b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: compare outputs mid-cycle, then advance the model.
    task automatic cycle(string lbl);
        int nhit = 0, ek = 0, esad = 0, elast = 0;
        hv[0] = int'(cur_vld);
        hi[0] = cur_first ? 0 : mcnt;
        hp[0] = int'(cur_pix);
        #1;
        for (int k = 0; k < NPE; k++) begin
            if (hv[k] != 0 && pe_en[k] && (hi[k] % 64) == 63) begin
                nhit++;
                ek = k;
                esad = (hi[k] == 0 ? 0 : macc[k]) + absd(hp[k], int'(ref_pix));
                elast = (hi[k] == 255) ? 1 : 0;
            end
        end
        chk(nhit <= 1, "R8 model hits", nhit, 1);
        chk(rep_vld == (nhit != 0), {lbl, " R3 rep_vld"}, int'(rep_vld), int'(nhit != 0));
        if (nhit == 1) begin
            chk(int'(rep_tag) == ek, {lbl, " R4 rep_tag"}, int'(rep_tag), ek);
            chk(int'(rep_last) == elast, {lbl, " R4 rep_last"}, int'(rep_last), elast);
            chk(int'(rep_sad) == esad, {lbl, " R2 rep_sad"}, int'(rep_sad), esad);
        end
        @(posedge clk);
        for (int k = 0; k < NPE; k++) begin
            if (hv[k] != 0) begin
                if (pe_en[k])
                    macc[k] = (hi[k] == 0 ? 0 : macc[k]) + absd(hp[k], int'(ref_pix));
                else if (hi[k] == 0)
                    macc[k] = 0;
            end
        end
        if (hv[0] != 0) mcnt = (hi[0] == 255) ? 0 : hi[0] + 1;
        for (int k = NPE - 1; k > 0; k--) begin
            hv[k] = hv[k-1]; hi[k] = hi[k-1]; hp[k] = hp[k-1];
        end
        @(negedge clk);
    endtask

    // Streams npix valid pixels from block index 0.
    // pmode: 0 random, 1 saturating, 2 random with bubbles.
    // emode: 0 all on, 1 fixed mask with random toggles.
    task automatic pass(string lbl, int npix, int pmode, int emode);
        int sent = 0;
        if (emode == 1) pe_en = 32'hA5A5_0F0F;
        while (sent < npix) begin
            cur_vld = 1'b1;
            if (pmode == 2 && ($urandom % 4) == 0) cur_vld = 1'b0;
            cur_first = cur_vld && (sent == 0);
            cur_pix = (pmode == 1) ? 8'd255 : 8'($urandom);
            ref_pix = (pmode == 1) ? 8'd0 : 8'($urandom);
            if (emode == 1 && ($urandom % 16) == 0) pe_en[$urandom % NPE] ^= 1'b1;
            if (cur_vld) sent++;
            cycle(lbl);
        end
        cur_vld = 1'b0; cur_first = 1'b0;
    endtask

    task automatic idle(string lbl, int n);
        for (int i = 0; i < n; i++) begin
            cur_vld = 1'b0; cur_first = 1'b0;
            ref_pix = 8'($urandom);
            cycle(lbl);
        end
    endtask

    initial begin
        for (int k = 0; k < NPE; k++) begin
            hv[k] = 0; hi[k] = 0; hp[k] = 0; macc[k] = 0;
        end
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            #1;
            chk(rep_vld == 1'b0, "R1 in reset", int'(rep_vld), 0);
            @(negedge clk);
        end
        rst_n = 1'b1;
        idle("R1 after reset", 5);
        pass("R3 random", 256, 0, 0);
        pass("R9 back-to-back", 256, 0, 0);
        idle("R9 drain", 40);
        pass("R7 saturate", 256, 1, 0);
        idle("R7 drain", 40);
        pass("R6 enable mask", 256, 0, 1);
        idle("R6 drain", 40);
        pe_en = '1;
        pass("R10 bubbles", 256, 2, 0);
        idle("R10 drain", 40);
        pass("R5 cut short", 100, 0, 0);
        pass("R5 restart", 256, 0, 0);
        idle("R5 drain", 40);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule